// File: doc/BRIEF.md
# Receive Frame Error Classifier

This block sits beside the receive path of an Ethernet MAC and watches each incoming frame byte by byte. It counts the bytes, forwards a write strobe for the bytes that fit into the receive buffer, and when the frame ends it combines the byte count, the external CRC result and the number of leftover bits into one status word. It then tells the buffer manager whether to keep or throw away what was written.

Three error kinds are tracked: bad CRC, undersize (runt) and oversize frames. Each has its own accept switch in a control word and its own interrupt enable in a configuration word, at the same bit position as its status flag. Oversize frames that are accepted are cut to the maximum length instead of being dropped. Leftover bits after the last whole byte are discarded, but their presence is flagged. When they occur together with a CRC error, the frame is also marked as misaligned.

The status word and the interrupt line are produced one cycle after the end-of-frame strobe. They keep their value until the first byte of the next frame clears them.

Top module: `rx_err_classifier`

## Requirements
- R1: One cycle after `eof_i`, bit 12 of `event_o` is 1 exactly when `crc_ok_i` was 0 at `eof_i`.
- R2: One cycle after `eof_i`, bit 13 of `event_o` is 1 exactly when the frame held fewer than MIN_LEN (64) bytes.
- R3: One cycle after `eof_i`, bit 14 of `event_o` is 1 exactly when the frame held more than MAX_LEN (1518) bytes.
- R4: One cycle after `eof_i`, bit 7 of `event_o` is 1 exactly when `leftover_i` (0 to 7 leftover bits) was nonzero at `eof_i`.
- R5: One cycle after `eof_i`, bit 8 of `event_o` (misalignment) is 1 exactly when bits 7 and 12 are both 1. All other bits of `event_o` stay 0.
- R6: One cycle after `eof_i`, exactly one of `commit_o` and `discard_o` pulses for one cycle. `commit_o` pulses when every error among bits 12, 13 and 14 that the frame shows has the bit at the same position set in `accept_i`. A frame with no such error is always committed. Neither pulse occurs at any other time.
- R7: `buf_wr_o` pulses one cycle after each input byte whose zero-based index in the frame is below MAX_LEN, with `buf_data_o` carrying that byte. Later bytes of the frame produce no write.
- R8: `stored_len_o` in the cycle of `commit_o` equals the smaller of the byte count and MAX_LEN. Leftover bits never change it.
- R9: One cycle after `eof_i`, `irq_o` is 1 exactly when any of event bits 12, 13 or 14 is set together with the bit at the same position in `irq_en_i`.
- R10: `event_o` and `irq_o` hold their values from one cycle after `eof_i` until a first-of-frame byte arrives. They read 0 in the cycle after that byte.
- R11: After reset, `event_o`, `irq_o`, `commit_o`, `discard_o` and `buf_wr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | A frame byte is present this cycle |
| sof_i | input | 1 | With byte_valid_i: this byte is the first of a frame |
| byte_i | input | 8 | Frame byte |
| eof_i | input | 1 | End-of-frame strobe, in a cycle after the last byte, never with a byte |
| leftover_i | input | 3 | Bits received after the last whole byte, valid with eof_i |
| crc_ok_i | input | 1 | External CRC check result, valid with eof_i |
| accept_i | input | 16 | Accept-anyway switches, bits 12/13/14 for CRC/runt/oversize |
| irq_en_i | input | 16 | Interrupt enables, bits 12/13/14 for CRC/runt/oversize |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_data_o | output | 8 | Byte to write |
| stored_len_o | output | 11 | Number of bytes kept in the buffer |
| commit_o | output | 1 | Keep the frame just written |
| discard_o | output | 1 | Drop the frame just written |
| event_o | output | 16 | Receive status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the length edges 63/64 and 1518/1519, and at frames far past the maximum. A design with an off-by-one comparator would flag the wrong frame there. A counter that wrapped instead of saturating would clear the oversize flag and report a wrong stored length. A design that writes one byte too many would corrupt the buffer. Random accept and enable words in which only some error bits are set catch a keep decision that takes any single accept bit as enough, or an interrupt that ignores its own enable position. Dribble bits with and without a CRC error catch a misalignment flag raised on dribble alone. Idle cycles between frames show whether the status word is held or cleared too early.

// File: rtl/rx_cls_pkg.sv
package rx_cls_pkg;

    localparam int EVT_W      = 16;
    localparam int BIT_DRIB   = 7;
    localparam int BIT_ALIGN  = 8;
    localparam int BIT_CRC    = 12;
    localparam int BIT_RUNT   = 13;
    localparam int BIT_XTRA   = 14;

    // Mask of the three error flags that take part in keep/irq decisions.
    localparam logic [EVT_W-1:0] ERR_MASK =
        (EVT_W'(1) << BIT_CRC) | (EVT_W'(1) << BIT_RUNT) | (EVT_W'(1) << BIT_XTRA);

endpackage

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
    parameter int MAX_LEN = 1518,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid_i,
    input  logic              sof_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] SATV = CNT_W'(MAX_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [DATA_W-1:0] data;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] idx;

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        idx       = sof_i ? '0 : st_q.cnt;
        if (byte_valid_i) begin
            // index of this byte decides whether it fits the buffer
            st_d.wr   = (idx < LIM);
            st_d.data = byte_i;
            if (sof_i) begin
                st_d.cnt = CNT_W'(1);
            end else if (st_q.cnt < SATV) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign wr_o    = st_q.wr;
    assign data_o  = st_q.data;

endmodule

// File: rtl/rx_err_decide.sv
module rx_err_decide
    import rx_cls_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [2:0]       leftover_i,
    input  logic             crc_ok_i,
    input  logic [EVT_W-1:0] accept_i,
    input  logic [EVT_W-1:0] irq_en_i,
    output logic [EVT_W-1:0] event_o,
    output logic             keep_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] stored_len_o
);
    localparam logic [CNT_W-1:0] MINV = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] MAXV = CNT_W'(MAX_LEN);

    logic is_crc, is_runt, is_xtra, is_drib;
    logic [EVT_W-1:0] err_bits;

    always_comb begin
        is_crc  = !crc_ok_i;
        is_runt = (count_i < MINV);
        is_xtra = (count_i > MAXV);
        is_drib = (leftover_i != 3'd0);

        event_o = '0;
        event_o[BIT_CRC]   = is_crc;
        event_o[BIT_RUNT]  = is_runt;
        event_o[BIT_XTRA]  = is_xtra;
        event_o[BIT_DRIB]  = is_drib;
        event_o[BIT_ALIGN] = is_drib && is_crc;

        err_bits     = event_o & ERR_MASK;
        // keep only when no present error lacks its accept switch
        keep_o       = ((err_bits & ~accept_i) == '0);
        irq_o        = ((err_bits & irq_en_i) != '0);
        stored_len_o = is_xtra ? MAXV : count_i;
    end

endmodule

// File: rtl/rx_err_classifier.sv
module rx_err_classifier
    import rx_cls_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid_i,
    input  logic              sof_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              eof_i,
    input  logic [2:0]        leftover_i,
    input  logic              crc_ok_i,
    input  logic [15:0]       accept_i,
    input  logic [15:0]       irq_en_i,
    output logic              buf_wr_o,
    output logic [DATA_W-1:0] buf_data_o,
    output logic [CNT_W-1:0]  stored_len_o,
    output logic              commit_o,
    output logic              discard_o,
    output logic [15:0]       event_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic             irq;
        logic             commit;
        logic             discard;
        logic [CNT_W-1:0] len;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CNT_W-1:0] count;
    logic [EVT_W-1:0] dec_evt;
    logic             dec_keep;
    logic             dec_irq;
    logic [CNT_W-1:0] dec_len;

    rx_len_counter #(
        .MAX_LEN (MAX_LEN),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid_i),
        .sof_i        (sof_i),
        .byte_i       (byte_i),
        .count_o      (count),
        .wr_o         (buf_wr_o),
        .data_o       (buf_data_o)
    );

    rx_err_decide #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_dec (
        .count_i      (count),
        .leftover_i   (leftover_i),
        .crc_ok_i     (crc_ok_i),
        .accept_i     (accept_i),
        .irq_en_i     (irq_en_i),
        .event_o      (dec_evt),
        .keep_o       (dec_keep),
        .irq_o        (dec_irq),
        .stored_len_o (dec_len)
    );

    always_comb begin
        st_d         = st_q;
        st_d.commit  = 1'b0;
        st_d.discard = 1'b0;
        if (eof_i) begin
            st_d.evt     = dec_evt;
            st_d.irq     = dec_irq;
            st_d.commit  = dec_keep;
            st_d.discard = !dec_keep;
            st_d.len     = dec_len;
        end else if (byte_valid_i && sof_i) begin
            st_d.evt = '0;
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o      = st_q.evt;
    assign irq_o        = st_q.irq;
    assign commit_o     = st_q.commit;
    assign discard_o    = st_q.discard;
    assign stored_len_o = st_q.len;

endmodule

// File: rtl/rx_err_classifier_chk.sv
module rx_err_classifier_chk #(
    parameter int MAX_LEN = 1518,
    parameter int CNT_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid_i,
    input logic             sof_i,
    input logic             eof_i,
    input logic             buf_wr_o,
    input logic [CNT_W-1:0] stored_len_o,
    input logic             commit_o,
    input logic             discard_o,
    input logic [15:0]      event_o,
    input logic             irq_o
);
    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && discard_o));

    // R6
    outcome_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_i |=> (commit_o ^ discard_o));

    // R6
    no_stray_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_i |=> !(commit_o || discard_o));

    // R5
    align_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_o[8] |-> (event_o[7] && event_o[12]));

    // R7
    write_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> !buf_wr_o);

    // R8
    len_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (stored_len_o <= CNT_W'(MAX_LEN)));

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eof_i && !(byte_valid_i && sof_i)) |=> ($stable(event_o) && $stable(irq_o)));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && sof_i && !eof_i) |=> (event_o == 16'd0 && !irq_o));

endmodule

bind rx_err_classifier rx_err_classifier_chk #(
    .MAX_LEN (MAX_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .buf_wr_o     (buf_wr_o),
    .stored_len_o (stored_len_o),
    .commit_o     (commit_o),
    .discard_o    (discard_o),
    .event_o      (event_o),
    .irq_o        (irq_o)
);

// File: tb/rx_err_classifier_bench.sv
module rx_err_classifier_bench;
    localparam int MINL = 64;
    localparam int MAXL = 1518;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic        sof_i = 1'b0;
    logic [7:0]  byte_i = 8'd0;
    logic        eof_i = 1'b0;
    logic [2:0]  leftover_i = 3'd0;
    logic        crc_ok_i = 1'b1;
    logic [15:0] accept_i = 16'd0;
    logic [15:0] irq_en_i = 16'd0;
    logic        buf_wr_o;
    logic [7:0]  buf_data_o;
    logic [10:0] stored_len_o;
    logic        commit_o;
    logic        discard_o;
    logic [15:0] event_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rx_err_classifier u_rx_err_classifier (
        .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .sof_i(sof_i),
        .byte_i(byte_i), .eof_i(eof_i), .leftover_i(leftover_i), .crc_ok_i(crc_ok_i),
        .accept_i(accept_i), .irq_en_i(irq_en_i), .buf_wr_o(buf_wr_o),
        .buf_data_o(buf_data_o), .stored_len_o(stored_len_o), .commit_o(commit_o),
        .discard_o(discard_o), .event_o(event_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_event(int len, int lo, bit crc_ok);
        logic [15:0] e = 16'd0;
        e[12] = !crc_ok;
        e[13] = (len < MINL);
        e[14] = (len > MAXL);
        e[7]  = (lo != 0);
        e[8]  = (lo != 0) && !crc_ok;
        return e;
    endfunction

    function automatic bit exp_keep(logic [15:0] e, logic [15:0] acc);
        logic [15:0] m = e & 16'h7000;
        return (m & ~acc) == 16'd0;
    endfunction

    // Send one frame, then check the end-of-frame outcome and the hold.
    task automatic send_frame(int len, int lo, bit crc_ok, logic [15:0] acc, logic [15:0] ien);
        int writes = 0;
        bit data_ok = 1'b1;
        logic [15:0] e;
        bit keep;
        accept_i = acc;
        irq_en_i = ien;
        for (int i = 0; i < len; i++) begin
            byte_valid_i = 1'b1;
            sof_i        = (i == 0);
            byte_i       = 8'(i * 7 + len);
            @(posedge clk);
            @(negedge clk);
            if (buf_wr_o) begin
                writes++;
                if (buf_data_o != 8'(i * 7 + len)) data_ok = 1'b0;
            end
            if (i == 0) begin
                // R10 status cleared after first byte
                check(event_o == 16'd0 && !irq_o, "R10", int'(event_o), 0);
            end
        end
        byte_valid_i = 1'b0;
        sof_i        = 1'b0;
        // R7 writes only for the first MAXL bytes, with the right data
        check(writes == ((len < MAXL) ? len : MAXL), "R7", writes, (len < MAXL) ? len : MAXL);
        check(data_ok, "R7", int'(data_ok), 1);
        eof_i      = 1'b1;
        leftover_i = 3'(lo);
        crc_ok_i   = crc_ok;
        @(posedge clk);
        @(negedge clk);
        eof_i      = 1'b0;
        leftover_i = 3'($urandom_range(0, 7));
        crc_ok_i   = 1'($urandom_range(0, 1));
        e    = exp_event(len, lo, crc_ok);
        keep = exp_keep(e, acc);
        // R1 R2 R3 R4 R5
        check(event_o == e, "R1-5 event word", int'(event_o), int'(e));
        // R6
        check(commit_o == keep && discard_o == !keep, "R6",
              int'({commit_o, discard_o}), int'({keep, !keep}));
        // R9
        check(irq_o == (((e & ien & 16'h7000) != 16'd0)), "R9", int'(irq_o),
              int'((e & ien & 16'h7000) != 16'd0));
        if (keep) begin
            // R8
            check(int'(stored_len_o) == ((len > MAXL) ? MAXL : len), "R8",
                  int'(stored_len_o), (len > MAXL) ? MAXL : len);
        end
        @(posedge clk);
        @(negedge clk);
        // R10 hold during idle, R6 pulse ended
        check(event_o == e && !commit_o && !discard_o, "R10", int'(event_o), int'(e));
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin : watchdog
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=expired expected=done");
                wd = 1;
            end
            begin : body
                void'($urandom(32'd4242));
                repeat (3) @(negedge clk);
                // R11
                check(event_o == 16'd0 && !irq_o && !commit_o && !discard_o && !buf_wr_o,
                      "R11", int'(event_o), 0);
                rst_n = 1'b1;
                @(negedge clk);
                check(event_o == 16'd0 && !irq_o, "R11", int'(event_o), 0);
                // R2 boundary: 63 runt, 64 not
                send_frame(63, 0, 1'b1, 16'h0000, 16'h2000);
                send_frame(64, 0, 1'b1, 16'h0000, 16'h2000);
                // R3 boundary and truncation
                send_frame(1518, 0, 1'b1, 16'h0000, 16'h4000);
                send_frame(1519, 0, 1'b1, 16'h4000, 16'h4000);
                send_frame(1600, 3, 1'b1, 16'h4000, 16'h0000);
                // R4/R5: dribble alone, dribble with CRC error
                send_frame(100, 5, 1'b1, 16'h0000, 16'hFFFF);
                send_frame(100, 1, 1'b0, 16'h1000, 16'h1000);
                // R6 partial accept: runt with CRC error, only CRC accepted
                send_frame(10, 0, 1'b0, 16'h1000, 16'h0000);
                send_frame(10, 0, 1'b0, 16'h3000, 16'h8FFF);
                // R1 CRC error without accept
                send_frame(200, 0, 1'b0, 16'h6000, 16'h1000);
                for (int k = 0; k < 40; k++) begin
                    int len;
                    len = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1505, 1535))
                                                      : int'($urandom_range(1, 160));
                    send_frame(len, int'($urandom_range(0, 7)),
                               1'($urandom_range(0, 1)),
                               16'($urandom), 16'($urandom));
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                end
                disable watchdog;
            end
        join_any
        disable fork;
        if (wd == 0) begin
            n_chk = n_chk;
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule